// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a clocked model of the command front end of a 16-bit-wide NOR flash with a 22-bit word address. Bus writes arrive as single-cycle strobes (`wr_en`) carrying an address and a data word. The block follows the multi-write unlock protocol and starts internal word programs or sector, block and whole-array erases. Each busy period is timed by a counter loaded from a parameter. A running sector or block erase can be paused and restarted. While it is paused, words outside the paused region can still be programmed.

A write-protect pin guards one 32K-word boot region, which is either the lowest or the highest block of the array, and it also prevents whole-array erase. Three query modes (identification, parameter query, security area) are entered by command sequences and left by an exit command. Any write that breaks a sequence returns the block to plain read mode. A status generator downstream takes the `busy`, `suspended`, `mode`, `op_kind` and `op_addr` outputs to build polling and toggle responses.

Top module: `nor_cmd_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no write, `busy`=0, `suspended`=0, `mode`=0 (read), `op_kind`=0 (none).
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by a write to any address, start a word program. From the cycle after that fourth write, `busy`=1 and `op_kind`=1 and `op_addr` is the written address, for exactly T_PROG cycles. Commands are matched on data bits 7:0 and address bits 10:0.
- R3: While `busy`=1, every write is ignored, including query-mode entry and the F0h exit. The only exception is the suspend command of R7.
- R4: The prefix AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, followed by a sixth write, starts an erase. The sixth write selects the kind. 50h erases the sector at address bits 21:11 (`op_kind`=2, T_SECT cycles). 30h erases the block at address bits 21:15 (`op_kind`=3, T_BLK cycles). 10h at 555h erases the whole array (`op_kind`=4, T_CHIP cycles).
- R5: A write that does not fit the expected sequence step aborts the sequence and sets `mode` to read.
- R6: The unlock pair followed by 90h@555h, 98h@555h or 88h@555h sets `mode` to 1 (identification), 2 (parameter query) or 3 (security area). A single F0h write returns `mode` to 0.
- R7: B0h written during a sector or block erase causes `suspended`=1 and `busy`=0 after T_SUSP cycles. The erase countdown stops from the cycle after the B0h write. B0h during a whole-array erase is ignored.
- R8: While suspended, a word program is accepted unless its address lies in the suspended sector (bits 21:11) or block (bits 21:15). A rejected program leaves `busy` at 0.
- R9: 30h written while suspended and not busy clears `suspended` and sets `busy`. The erase then completes after the cycles that were left when it was paused.
- R10: With `wp_n` low, programs and sector or block erases aimed at the boot block are ignored, and whole-array erase is ignored. The boot block is address bits 21:15 = 0 when BOOT_TOP=0, and 7Fh when BOOT_TOP=1.
- R11: Driving `rst_n` low aborts any running or suspended operation and returns `busy`, `suspended`, `mode` and `op_kind` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts operations |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Data of the write; bits 7:0 carry commands |
| wp_n | input | 1 | Active-low boot-block write protect |
| busy | output | 1 | Internal program or erase in progress |
| suspended | output | 1 | Sector/block erase paused |
| mode | output | 2 | 0 read, 1 identification, 2 parameter query, 3 security area |
| op_kind | output | 3 | 0 none, 1 program, 2 sector, 3 block, 4 array erase |
| op_addr | output | 22 | Target address of the reported operation |

## Verification
The bench builds the block with T_PROG=4, T_SECT=12, T_BLK=20, T_CHIP=30, T_SUSP=3 and BOOT_TOP=0. With these values, the exact first idle cycle of every operation can be checked in a few dozen cycles. Suspend latency and the frozen remaining count after resume become exact cycle checks, because a write lands while at most a handful of cycles have elapsed. With a bottom boot block, protected targets sit at low addresses, so they are easy to contrast with accepted targets higher up.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int T_PROG   = 700,
  parameter int T_SECT   = 1800000,
  parameter int T_BLK    = 1800000,
  parameter int T_CHIP   = 4000000,
  parameter int T_SUSP   = 2000,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [21:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic        wp_n,
  output logic        busy,
  output logic        suspended,
  output logic [1:0]  mode,
  output logic [2:0]  op_kind,
  output logic [21:0] op_addr
);
  localparam int TMAX1 = (T_PROG > T_SECT) ? T_PROG : T_SECT;
  localparam int TMAX2 = (T_BLK > T_CHIP) ? T_BLK : T_CHIP;
  localparam int TMAX3 = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TMAX  = (TMAX3 > T_SUSP) ? TMAX3 : T_SUSP;
  localparam int CW    = $clog2(TMAX + 1);
  localparam logic [6:0] BOOT_TAG = BOOT_TOP ? 7'h7F : 7'h00;

  localparam logic [2:0] K_NONE = 3'd0, K_PROG = 3'd1, K_SECT = 3'd2,
                         K_BLK  = 3'd3, K_CHIP = 3'd4;
  localparam logic [1:0] M_READ = 2'd0, M_ID = 2'd1, M_CFG = 2'd2, M_SEC = 2'd3;
  localparam logic [2:0] S_IDLE = 3'd0, S_U1 = 3'd1, S_U2 = 3'd2, S_PG = 3'd3,
                         S_E1   = 3'd4, S_E2 = 3'd5, S_E3 = 3'd6;

  logic [2:0]    step;
  logic [1:0]    mode_q;
  logic [CW-1:0] prog_cnt, er_cnt, susp_cnt;
  logic          er_susp;
  logic [2:0]    er_kind;
  logic [21:0]   prog_addr, er_addr;

  wire [7:0] cmd       = wr_data[7:0];
  wire       at555     = wr_addr[10:0] == 11'h555;
  wire       at2aa     = wr_addr[10:0] == 11'h2AA;
  wire       prog_busy = prog_cnt != '0;
  wire       er_live   = er_cnt != '0;
  wire       er_run    = er_live && !er_susp && susp_cnt == '0;
  wire       locked    = !wp_n && wr_addr[21:15] == BOOT_TAG;
  wire       same_reg  = (er_kind == K_SECT) ? wr_addr[21:11] == er_addr[21:11]
                                             : wr_addr[21:15] == er_addr[21:15];
  wire       susp_hit  = er_susp && same_reg;

  assign busy      = prog_busy || (er_live && !er_susp);
  assign suspended = er_susp;
  assign mode      = mode_q;
  assign op_kind   = prog_busy ? K_PROG : (er_live ? er_kind : K_NONE);
  assign op_addr   = prog_busy ? prog_addr : er_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= S_IDLE;
      mode_q    <= M_READ;
      prog_cnt  <= '0;
      er_cnt    <= '0;
      susp_cnt  <= '0;
      er_susp   <= 1'b0;
      er_kind   <= K_NONE;
      prog_addr <= '0;
      er_addr   <= '0;
    end else begin
      if (prog_busy) prog_cnt <= prog_cnt - 1'b1;
      if (er_run)    er_cnt   <= er_cnt - 1'b1;
      if (susp_cnt != '0) begin
        susp_cnt <= susp_cnt - 1'b1;
        if (susp_cnt == CW'(1)) er_susp <= 1'b1;
      end
      if (wr_en) begin
        if (busy) begin
          if (er_run && !prog_busy && er_kind != K_CHIP && cmd == 8'hB0)
            susp_cnt <= CW'(T_SUSP);
        end else if (er_susp && cmd == 8'h30) begin
          er_susp <= 1'b0;
          step    <= S_IDLE;
        end else begin
          case (step)
            S_IDLE: if (cmd == 8'hAA && at555) step <= S_U1;
                    else mode_q <= M_READ;
            S_U1, S_E2: begin
              if (cmd == 8'h55 && at2aa) step <= (step == S_U1) ? S_U2 : S_E3;
              else begin step <= S_IDLE; mode_q <= M_READ; end
            end
            S_E1: begin
              if (cmd == 8'hAA && at555) step <= S_E2;
              else begin step <= S_IDLE; mode_q <= M_READ; end
            end
            S_U2: begin
              step <= S_IDLE;
              if (!at555) mode_q <= M_READ;
              else case (cmd)
                8'hA0:   step   <= S_PG;
                8'h80:   step   <= S_E1;
                8'h90:   mode_q <= M_ID;
                8'h98:   mode_q <= M_CFG;
                8'h88:   mode_q <= M_SEC;
                default: mode_q <= M_READ;
              endcase
            end
            S_PG: begin
              step   <= S_IDLE;
              mode_q <= M_READ;
              if (!locked && !susp_hit) begin
                prog_cnt  <= CW'(T_PROG);
                prog_addr <= wr_addr;
              end
            end
            S_E3: begin
              step    <= S_IDLE;
              mode_q  <= M_READ;
              er_addr <= er_addr;
              if (!er_susp) begin
                if (cmd == 8'h50 && !locked) begin
                  er_cnt <= CW'(T_SECT); er_kind <= K_SECT; er_addr <= wr_addr;
                end else if (cmd == 8'h30 && !locked) begin
                  er_cnt <= CW'(T_BLK);  er_kind <= K_BLK;  er_addr <= wr_addr;
                end else if (cmd == 8'h10 && at555 && wp_n) begin
                  er_cnt <= CW'(T_CHIP); er_kind <= K_CHIP; er_addr <= wr_addr;
                end
              end
            end
            default: step <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

module nor_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        wp_n,
  input logic        busy,
  input logic        suspended,
  input logic [1:0]  mode,
  input logic [2:0]  op_kind
);
  // R3
  busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(mode));

  // R5
  idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode));

  // R2
  busy_has_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> op_kind != 3'd0);

  // R7
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> !busy && op_kind != 3'd4);

  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !busy && wr_en && wr_data[7:0] == 8'h30 |=> !suspended && busy);

  // R10
  no_locked_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !$past(wp_n) |-> op_kind != 3'd4);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk chk_i (.*);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;
  localparam int TP = 4, TS = 12, TB = 20, TC = 30, TU = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wp_n = 1'b1;
  logic        busy, suspended;
  logic [1:0]  mode;
  logic [2:0]  op_kind;
  logic [21:0] op_addr;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.T_PROG(TP), .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC),
                .T_SUSP(TU), .BOOT_TOP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_n(wp_n), .busy(busy), .suspended(suspended),
    .mode(mode), .op_kind(op_kind), .op_addr(op_addr));

  typedef struct {
    string       tag;
    logic [1:0]  mode;
    logic        busy;
    logic        susp;
    logic [2:0]  kind;
    bit          chk_addr;
    logic [21:0] addr;
  } exp_t;

  exp_t exp_q[$];
  event push_ev;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  task automatic expect_st(string tag, logic [1:0] m, logic b, logic s,
                           logic [2:0] k, bit ca = 1'b0, logic [21:0] a = '0);
    exp_t e;
    e.tag = tag; e.mode = m; e.busy = b; e.susp = s; e.kind = k;
    e.chk_addr = ca; e.addr = a;
    exp_q.push_back(e);
    -> push_ev;
  endtask

  initial begin
    forever begin
      @(push_ev);
      while (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (mode !== e.mode || busy !== e.busy || suspended !== e.susp ||
            op_kind !== e.kind || (e.chk_addr && op_addr !== e.addr)) begin
          errors++;
          $display("FAIL %s: got mode=%0d busy=%0b susp=%0b kind=%0d addr=%h, exp mode=%0d busy=%0b susp=%0b kind=%0d addr=%h",
                   e.tag, mode, busy, suspended, op_kind, op_addr,
                   e.mode, e.busy, e.susp, e.kind, e.addr);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [21:0] a, logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd3(logic [7:0] c);
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, {8'h00, c});
  endtask

  task automatic prog(logic [21:0] a);
    cmd3(8'hA0);
    wr(a, 16'h1234);
  endtask

  task automatic erase(logic [7:0] c, logic [21:0] a);
    cmd3(8'h80);
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(a, {8'h00, c});
  endtask

  initial begin
    wait_cyc(3);
    #1;
    expect_st("R1 in reset", 2'd0, 0, 0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(2);
    expect_st("R1 after release", 2'd0, 0, 0, 3'd0);

    prog(22'h123456);
    expect_st("R2 program start", 2'd0, 1, 0, 3'd1, 1'b1, 22'h123456);
    wait_cyc(TP - 1);
    expect_st("R2 program last busy", 2'd0, 1, 0, 3'd1);
    wait_cyc(1);
    expect_st("R2 program done", 2'd0, 0, 0, 3'd0);

    prog(22'h200000);
    cmd3(8'h90);
    wait_cyc(1);
    expect_st("R3 id entry ignored while busy", 2'd0, 0, 0, 3'd0);

    cmd3(8'h90);
    expect_st("R6 id mode", 2'd1, 0, 0, 3'd0);
    erase(8'h50, 22'h0C0000);
    cmd3(8'h98);
    wait_cyc(1);
    expect_st("R3 cfg entry ignored during erase", 2'd0, 1, 0, 3'd2);
    wait_cyc(TS);
    wr(22'h000000, 16'h00F0);
    expect_st("R6 exit to read", 2'd0, 0, 0, 3'd0);
    cmd3(8'h98);
    expect_st("R6 parameter query mode", 2'd2, 0, 0, 3'd0);
    wr(22'h555, 16'h00AA);
    wr(22'h100, 16'h0055);
    expect_st("R5 bad unlock address aborts", 2'd0, 0, 0, 3'd0);
    cmd3(8'h88);
    expect_st("R6 security mode", 2'd3, 0, 0, 3'd0);
    wr(22'h000000, 16'h0012);
    expect_st("R5 stray write to read", 2'd0, 0, 0, 3'd0);
    wr(22'h555, 16'h00AA);
    wr(22'h2AA, 16'h0055);
    wr(22'h555, 16'h0077);
    wr(22'h000000, 16'h1234);
    expect_st("R5 unknown command no program", 2'd0, 0, 0, 3'd0);

    erase(8'h50, 22'h1A3800);
    expect_st("R4 sector start", 2'd0, 1, 0, 3'd2, 1'b1, 22'h1A3800);
    wait_cyc(TS - 1);
    expect_st("R4 sector last busy", 2'd0, 1, 0, 3'd2);
    wait_cyc(1);
    expect_st("R4 sector done", 2'd0, 0, 0, 3'd0);
    erase(8'h30, 22'h2F0000);
    expect_st("R4 block start", 2'd0, 1, 0, 3'd3, 1'b1, 22'h2F0000);
    wait_cyc(TB - 1);
    expect_st("R4 block last busy", 2'd0, 1, 0, 3'd3);
    wait_cyc(1);
    expect_st("R4 block done", 2'd0, 0, 0, 3'd0);
    erase(8'h10, 22'h000555);
    expect_st("R4 chip start", 2'd0, 1, 0, 3'd4);
    wait_cyc(TC - 1);
    expect_st("R4 chip last busy", 2'd0, 1, 0, 3'd4);
    wait_cyc(1);
    expect_st("R4 chip done", 2'd0, 0, 0, 3'd0);

    erase(8'h50, 22'h208000);
    wait_cyc(2);
    wr(22'h000000, 16'h00B0);
    wait_cyc(TU - 1);
    expect_st("R7 suspend latency", 2'd0, 1, 0, 3'd2);
    wait_cyc(1);
    expect_st("R7 suspended", 2'd0, 0, 1, 3'd2, 1'b1, 22'h208000);
    prog(22'h208010);
    expect_st("R8 same sector program rejected", 2'd0, 0, 1, 3'd2);
    prog(22'h300000);
    expect_st("R8 other sector program accepted", 2'd0, 1, 1, 3'd1, 1'b1, 22'h300000);
    wait_cyc(TP);
    expect_st("R8 program done still suspended", 2'd0, 0, 1, 3'd2);
    wr(22'h000000, 16'h0030);
    expect_st("R9 resumed", 2'd0, 1, 0, 3'd2);
    wait_cyc(TS - 4);
    expect_st("R9 remaining count busy", 2'd0, 1, 0, 3'd2);
    wait_cyc(1);
    expect_st("R9 resumed erase done", 2'd0, 0, 0, 3'd0);

    wp_n = 1'b0;
    prog(22'h001000);
    expect_st("R10 boot program blocked", 2'd0, 0, 0, 3'd0);
    erase(8'h50, 22'h004000);
    expect_st("R10 boot sector erase blocked", 2'd0, 0, 0, 3'd0);
    erase(8'h10, 22'h000555);
    expect_st("R10 chip erase blocked", 2'd0, 0, 0, 3'd0);
    prog(22'h100000);
    expect_st("R10 unprotected program ok", 2'd0, 1, 0, 3'd1);
    wait_cyc(TP);
    wp_n = 1'b1;
    prog(22'h001000);
    expect_st("R10 boot program with wp_n high", 2'd0, 1, 0, 3'd1, 1'b1, 22'h001000);
    wait_cyc(TP);

    erase(8'h10, 22'h000555);
    wr(22'h000000, 16'h00B0);
    wait_cyc(TU + 1);
    expect_st("R7 chip erase not suspendable", 2'd0, 1, 0, 3'd4);
    rst_n = 1'b0;
    #1;
    expect_st("R11 reset aborts", 2'd0, 0, 0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(2);
    expect_st("R11 idle after reset", 2'd0, 0, 0, 3'd0);

    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule